// File: doc/BRIEF.md
# Sequencer Microcode Load Port

This block lets a host processor fill the instruction RAM of an embedded sequencer one byte at a time. The host first writes a control register to turn on load mode. It then writes program bytes, one after another, into a single byte-wide data window. Each run of four bytes, least significant first, is gathered into one 32-bit instruction. That instruction is stored at the current word address, and the address then advances on its own. The address is visible through two byte-wide registers, so the host can follow progress. Writing the self-clearing reset bit returns the address to zero, and the host polls the address registers until they read zero.

Each stored word carries one even-parity bit. The sequencer reads the RAM through a fetch port that has one cycle of latency. A fetched word whose stored parity does not match raises a parity-error output, unless the control register has parity detection switched off. The other control bits (pause disable, fail disable, fast mode, breakpoint interrupt enable and single step) are held and presented to the sequencer unchanged.

Top module: `seq_ram_loader`

## Requirements
- R1: After reset the control register (index 0) reads 0x00, and both address registers (index 2 low byte, index 3 high byte) read 0x00.
- R2: A write to the control register at index 0 stores bits 7 (parity check off), 6 (pause off), 5 (fail off), 4 (fast), 3 (break interrupt enable) and 0 (load enable), and they read back unchanged. Bit 2 (single step) is also stored. Bit 1 (sequencer reset) always reads back 0, and the value on `seq_ctl_o` equals the value read back.
- R3: With load enable set, four writes to the data window (index 1) form one word, with the first byte in bits 7:0 and the fourth byte in bits 31:24. The word is stored at the word address that was current when the first of the four bytes was written.
- R4: The word address increments exactly once per four data writes, and only on the fourth. After the first, second or third byte of a word it reads unchanged.
- R5: A data write while load enable is clear is ignored. The address does not move and no RAM word changes.
- R6: A control write with bit 1 set returns the address to 0 on the next cycle and discards any partly gathered word.
- R7: A control write that sets load enable while it was clear discards a partly gathered word. A control write with load enable already set does not discard it.
- R8: The word address wraps from 511 to 0 after a word is stored at 511.
- R9: A fetch of a word stored with `perr_inject_i` high raises `perr_o` one cycle later if control bit 7 is clear. With bit 7 set, `perr_o` stays low. A fetch of a word stored with correct parity never raises `perr_o`.
- R10: The low address register holds address bits 7:0. Bit 0 of the high address register holds address bit 8, and its other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_wr_i | input | 1 | Host register write strobe |
| host_idx_i | input | 2 | Register index: 0 control, 1 data window, 2 address low, 3 address high |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Host read data for `host_idx_i` (combinational) |
| perr_inject_i | input | 1 | Store the next completed word with inverted parity |
| fetch_en_i | input | 1 | Sequencer fetch request |
| fetch_addr_i | input | 9 | Sequencer fetch word address |
| fetch_word_o | output | 32 | Fetched instruction, valid the cycle after the request |
| perr_o | output | 1 | Parity error for the last fetch |
| seq_ctl_o | output | 8 | Held control bits for the sequencer |

## Verification
The bench targets the byte-lane boundary. A design that advanced the address on every byte, or packed the bytes most significant first, stores scrambled words at the wrong addresses. Partial words cut off by a reset write or by a fresh load enable are checked: a design that kept the stale lane count would shift every following word by one to three bytes. Writes with load disabled, the wrap at 511, and parity faults fetched with detection on and off are also exercised. Getting these wrong shows as a moved address, a word that changed, or a missing or spurious error.

// File: rtl/seq_ld_pkg.sv
package seq_ld_pkg;

   typedef enum logic [1:0] {
      IDX_CTL    = 2'd0,
      IDX_DATA   = 2'd1,
      IDX_ADR_LO = 2'd2,
      IDX_ADR_HI = 2'd3
   } reg_idx_e;

   localparam int CB_PCHK_OFF = 7;
   localparam int CB_PAUSE_OFF = 6;
   localparam int CB_FAIL_OFF = 5;
   localparam int CB_FAST = 4;
   localparam int CB_BRK_EN = 3;
   localparam int CB_STEP = 2;
   localparam int CB_SRST = 1;
   localparam int CB_LOAD = 0;

endpackage

// File: rtl/seq_ld_ctl.sv
module seq_ld_ctl
   import seq_ld_pkg::*;
#(
   parameter int CTL_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_i,
   input  logic [CTL_W-1:0] wdata_i,
   output logic [CTL_W-1:0] ctl_o,
   output logic             srst_o,
   output logic             restart_o
);

   logic [CTL_W-1:0] ctl_q;

   initial begin
      if (CTL_W != 8) $error("seq_ld_ctl: CTL_W must be 8");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctl_q <= '0;
      end else if (wr_i) begin
         ctl_q         <= wdata_i;
         ctl_q[CB_SRST] <= 1'b0;
      end
   end

   assign ctl_o     = ctl_q;
   assign srst_o    = wr_i & wdata_i[CB_SRST];
   assign restart_o = wr_i & wdata_i[CB_LOAD] & ~ctl_q[CB_LOAD];

endmodule

// File: rtl/seq_ld_asm.sv
module seq_ld_asm #(
   parameter int BYTE_W     = 8,
   parameter int WORD_BYTES = 4,
   parameter int ADDR_W     = 9,
   localparam int WORD_W    = BYTE_W * WORD_BYTES,
   localparam int LANE_W    = $clog2(WORD_BYTES)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              byte_wr_i,
   input  logic [BYTE_W-1:0] byte_i,
   input  logic              lane_clr_i,
   input  logic              addr_clr_i,
   output logic              we_o,
   output logic [ADDR_W-1:0] waddr_o,
   output logic [WORD_W-1:0] wword_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [LANE_W-1:0] lane_o
);

   localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(WORD_BYTES - 1);

   logic [LANE_W-1:0]              lane_q;
   logic [ADDR_W-1:0]              addr_q;
   logic [WORD_BYTES-2:0][BYTE_W-1:0] hold_q;
   logic                           last;

   initial begin
      if (WORD_BYTES < 2) $error("seq_ld_asm: WORD_BYTES must be at least 2");
      if ((1 << LANE_W) != WORD_BYTES) $error("seq_ld_asm: WORD_BYTES must be a power of two");
   end

   assign last = byte_wr_i & ~lane_clr_i & (lane_q == LAST_LANE);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         lane_q <= '0;
      end else if (lane_clr_i) begin
         lane_q <= '0;
      end else if (byte_wr_i) begin
         lane_q <= (lane_q == LAST_LANE) ? '0 : lane_q + 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         addr_q <= '0;
      end else if (addr_clr_i) begin
         addr_q <= '0;
      end else if (last) begin
         addr_q <= addr_q + 1'b1;
      end
   end

   for (genvar g = 0; g < WORD_BYTES - 1; g++) begin : g_lane
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            hold_q[g] <= '0;
         end else if (byte_wr_i && !lane_clr_i && lane_q == LANE_W'(g)) begin
            hold_q[g] <= byte_i;
         end
      end
   end

   assign we_o    = last;
   assign waddr_o = addr_q;
   assign wword_o = {byte_i, hold_q};
   assign addr_o  = addr_q;
   assign lane_o  = lane_q;

endmodule

// File: rtl/seq_ld_ram.sv
module seq_ld_ram #(
   parameter int WORD_W    = 32,
   parameter int ADDR_W    = 9,
   parameter bit PARITY_EN = 1'b1,
   localparam int DEPTH    = 1 << ADDR_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              we_i,
   input  logic [ADDR_W-1:0] waddr_i,
   input  logic [WORD_W-1:0] wword_i,
   input  logic              inject_i,
   input  logic              re_i,
   input  logic [ADDR_W-1:0] raddr_i,
   input  logic              chk_off_i,
   output logic [WORD_W-1:0] rword_o,
   output logic              perr_o
);

   initial begin
      if (DEPTH > 4096) $error("seq_ld_ram: depth too large");
   end

   if (PARITY_EN) begin : g_par
      logic [WORD_W:0] mem [DEPTH];
      logic [WORD_W:0] rd_q;
      logic            perr_q;

      always_ff @(posedge clk_i) begin
         if (we_i) mem[waddr_i] <= {(^wword_i) ^ inject_i, wword_i};
         if (re_i) rd_q <= mem[raddr_i];
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            perr_q <= 1'b0;
         end else if (re_i) begin
            perr_q <= (^mem[raddr_i]) & ~chk_off_i;
         end
      end

      assign rword_o = rd_q[WORD_W-1:0];
      assign perr_o  = perr_q;
   end else begin : g_nopar
      logic [WORD_W-1:0] mem [DEPTH];
      logic [WORD_W-1:0] rd_q;

      always_ff @(posedge clk_i) begin
         if (we_i) mem[waddr_i] <= wword_i;
         if (re_i) rd_q <= mem[raddr_i];
      end

      assign rword_o = rd_q;
      assign perr_o  = 1'b0;
   end

endmodule

// File: rtl/seq_ram_loader.sv
module seq_ram_loader
   import seq_ld_pkg::*;
#(
   parameter int BYTE_W     = 8,
   parameter int WORD_BYTES = 4,
   parameter int ADDR_W     = 9,
   parameter bit PARITY_EN  = 1'b1,
   localparam int WORD_W    = BYTE_W * WORD_BYTES,
   localparam int LANE_W    = $clog2(WORD_BYTES)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              host_wr_i,
   input  logic [1:0]        host_idx_i,
   input  logic [BYTE_W-1:0] host_wdata_i,
   output logic [BYTE_W-1:0] host_rdata_o,
   input  logic              perr_inject_i,
   input  logic              fetch_en_i,
   input  logic [ADDR_W-1:0] fetch_addr_i,
   output logic [WORD_W-1:0] fetch_word_o,
   output logic              perr_o,
   output logic [BYTE_W-1:0] seq_ctl_o
);

   logic [BYTE_W-1:0] ctl;
   logic              srst, restart, ctl_wr, byte_wr;
   logic              ram_we;
   logic [ADDR_W-1:0] waddr, addr;
   logic [WORD_W-1:0] wword;
   logic [LANE_W-1:0] lane;
   logic [2*BYTE_W-1:0] addr_ext;

   initial begin
      if (BYTE_W != 8) $error("seq_ram_loader: BYTE_W must be 8");
      if (ADDR_W <= BYTE_W || ADDR_W > 2 * BYTE_W)
         $error("seq_ram_loader: ADDR_W must fit two address bytes");
   end

   assign ctl_wr  = host_wr_i & (host_idx_i == IDX_CTL);
   assign byte_wr = host_wr_i & (host_idx_i == IDX_DATA) & ctl[CB_LOAD];

   seq_ld_ctl #(.CTL_W(BYTE_W)) i_ctl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_i      (ctl_wr),
      .wdata_i   (host_wdata_i),
      .ctl_o     (ctl),
      .srst_o    (srst),
      .restart_o (restart)
   );

   seq_ld_asm #(.BYTE_W(BYTE_W), .WORD_BYTES(WORD_BYTES), .ADDR_W(ADDR_W)) i_asm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .byte_wr_i  (byte_wr),
      .byte_i     (host_wdata_i),
      .lane_clr_i (srst | restart),
      .addr_clr_i (srst),
      .we_o       (ram_we),
      .waddr_o    (waddr),
      .wword_o    (wword),
      .addr_o     (addr),
      .lane_o     (lane)
   );

   seq_ld_ram #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .PARITY_EN(PARITY_EN)) i_ram (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (ram_we),
      .waddr_i   (waddr),
      .wword_i   (wword),
      .inject_i  (perr_inject_i),
      .re_i      (fetch_en_i),
      .raddr_i   (fetch_addr_i),
      .chk_off_i (ctl[CB_PCHK_OFF]),
      .rword_o   (fetch_word_o),
      .perr_o    (perr_o)
   );

   assign addr_ext = {{(2*BYTE_W-ADDR_W){1'b0}}, addr};

   always_comb begin
      unique case (host_idx_i)
         IDX_CTL:    host_rdata_o = ctl;
         IDX_DATA:   host_rdata_o = '0;
         IDX_ADR_LO: host_rdata_o = addr_ext[BYTE_W-1:0];
         default:    host_rdata_o = addr_ext[2*BYTE_W-1:BYTE_W];
      endcase
   end

   assign seq_ctl_o = ctl;

endmodule

// File: rtl/seq_ram_loader_chk.sv
module seq_ram_loader_chk #(
   parameter int ADDR_W = 9,
   parameter int LANE_W = 2
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              host_wr_i,
   input logic [1:0]        host_idx_i,
   input logic [7:0]        host_wdata_i,
   input logic [7:0]        ctl,
   input logic [ADDR_W-1:0] addr,
   input logic [LANE_W-1:0] lane,
   input logic              ram_we,
   input logic              perr_o
);

   localparam logic [ADDR_W-1:0] TOP = '1;
   localparam logic [LANE_W-1:0] LAST = '1;

   assert_mid_word_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (host_wr_i && host_idx_i == 2'd1 && ctl[0] && lane != LAST) |=> $stable(addr));

   assert_unloaded_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (host_wr_i && host_idx_i == 2'd1 && !ctl[0]) |-> !ram_we);

   assert_unloaded_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (host_wr_i && host_idx_i == 2'd1 && !ctl[0]) |=> $stable(addr));

   assert_reset_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (host_wr_i && host_idx_i == 2'd0 && host_wdata_i[1]) |=> (addr == '0 && lane == '0));

   assert_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ram_we && addr == TOP && !(host_wr_i && host_idx_i == 2'd0)) |=> (addr == '0));

   assert_srst_reads_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (host_wr_i && host_idx_i == 2'd0) |=> !ctl[1]);

   assert_perr_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(perr_o) |-> !$past(ctl[7]));

endmodule

bind seq_ram_loader seq_ram_loader_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) i_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .host_wr_i    (host_wr_i),
   .host_idx_i   (host_idx_i),
   .host_wdata_i (host_wdata_i),
   .ctl          (ctl),
   .addr         (addr),
   .lane         (lane),
   .ram_we       (ram_we),
   .perr_o       (perr_o)
);

// File: tb/test_seq_ram_loader.sv
module test_seq_ram_loader;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0;
   logic [1:0]  host_idx = 2'd0;
   logic [7:0]  host_wdata = 8'd0;
   logic [7:0]  host_rdata;
   logic        inject = 1'b0;
   logic        fetch_en = 1'b0;
   logic [8:0]  fetch_addr = 9'd0;
   logic [31:0] fetch_word;
   logic        perr;
   logic [7:0]  seq_ctl;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // bench model
   logic [31:0] m_mem [512];
   bit          m_bad [512];
   bit          m_val [512];
   logic [8:0]  m_addr;
   int          m_lane;
   logic [23:0] m_hold;
   logic [7:0]  m_ctl;

   always #10 clk = ~clk;

   seq_ram_loader i_seq_ram_loader (
      .clk_i(clk), .rst_ni(rst_n), .host_wr_i(host_wr), .host_idx_i(host_idx),
      .host_wdata_i(host_wdata), .host_rdata_o(host_rdata), .perr_inject_i(inject),
      .fetch_en_i(fetch_en), .fetch_addr_i(fetch_addr), .fetch_word_o(fetch_word),
      .perr_o(perr), .seq_ctl_o(seq_ctl)
   );

   task automatic check(input logic [63:0] got, input logic [63:0] exp, input string req);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   // bench model of a control write
   function automatic void m_ctl_wr(input logic [7:0] v);
      if (v[1]) begin m_addr = '0; m_lane = 0; end
      if (v[0] && !m_ctl[0]) m_lane = 0;
      m_ctl = v & 8'hFD;
   endfunction

   // bench model of a data write
   function automatic void m_data_wr(input logic [7:0] v, input bit inj);
      if (!m_ctl[0]) return;
      if (m_lane == 3) begin
         m_mem[m_addr] = {v, m_hold};
         m_bad[m_addr] = inj;
         m_val[m_addr] = 1'b1;
         m_addr = m_addr + 1'b1;
         m_lane = 0;
      end else begin
         m_hold[m_lane*8 +: 8] = v;
         m_lane++;
      end
   endfunction

   task automatic wr(input logic [1:0] idx, input logic [7:0] v);
      @(negedge clk);
      host_wr = 1'b1; host_idx = idx; host_wdata = v;
      if (idx == 2'd0) m_ctl_wr(v);
      else if (idx == 2'd1) m_data_wr(v, inject);
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] idx, output logic [7:0] v);
      host_idx = idx;
      #1 v = host_rdata;
   endtask

   task automatic chk_addr(input string req);
      logic [7:0] lo, hi;
      rd(2'd2, lo);
      rd(2'd3, hi);
      check({hi, lo}, {7'd0, m_addr}, req);
   endtask

   task automatic fetch(input logic [8:0] a, output logic [31:0] w, output logic pe);
      @(negedge clk);
      fetch_en = 1'b1; fetch_addr = a;
      @(negedge clk);
      fetch_en = 1'b0;
      w = fetch_word; pe = perr;
   endtask

   task automatic load_word(input logic [31:0] w);
      for (int b = 0; b < 4; b++) wr(2'd1, w[b*8 +: 8]);
   endtask

   initial begin
      int cyc = 0;
      while (cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [7:0]  v;
      logic [31:0] w;
      logic        pe;
      void'($urandom(32'h5EED_1234));
      m_addr = '0; m_lane = 0; m_hold = '0; m_ctl = '0;
      for (int i = 0; i < 512; i++) begin m_val[i] = 1'b0; m_bad[i] = 1'b0; m_mem[i] = '0; end

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd(2'd0, v); check(v, 8'h00, "R1 ctl");
      chk_addr("R1 addr");

      // R2: control readback, reset bit self-clears
      wr(2'd0, 8'hFE);
      rd(2'd0, v); check(v, 8'hFC, "R2 readback");
      check(seq_ctl, 8'hFC, "R2 seq_ctl");
      wr(2'd0, 8'h00);

      // R5: data writes ignored while load clear
      wr(2'd1, 8'h11); wr(2'd1, 8'h22); wr(2'd1, 8'h33); wr(2'd1, 8'h44);
      chk_addr("R5 addr");

      // load sequence: parity off, reset, load
      wr(2'd0, 8'h83);
      chk_addr("R6 addr zero");
      // R3/R4: byte ordering and increment point
      for (int b = 0; b < 4; b++) begin
         wr(2'd1, 8'hA0 + 8'(b));
         chk_addr("R4 per byte");
      end
      load_word(32'hCAFE_F00D);
      chk_addr("R4 two words");
      fetch(9'd0, w, pe); check(w, 32'hA3A2_A1A0, "R3 word0");
      fetch(9'd1, w, pe); check(w, 32'hCAFE_F00D, "R3 word1");

      // R5: unloaded write does not touch word at address
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h55); wr(2'd1, 8'h55); wr(2'd1, 8'h55); wr(2'd1, 8'h55);
      chk_addr("R5 addr hold");
      wr(2'd0, 8'h01);
      load_word(32'h0BAD_BEEF);
      fetch(9'd2, w, pe); check(w, 32'h0BAD_BEEF, "R5 no stray bytes");

      // R6: reset discards partial word
      wr(2'd1, 8'h77); wr(2'd1, 8'h66);
      wr(2'd0, 8'h03);
      chk_addr("R6 zero");
      load_word(32'h1234_5678);
      fetch(9'd0, w, pe); check(w, 32'h1234_5678, "R6 lane cleared");

      // R7: re-arming load discards partial word; rewrite with load set does not
      wr(2'd1, 8'h99);
      wr(2'd0, 8'h00); wr(2'd0, 8'h01);
      load_word(32'h8765_4321);
      fetch(9'd1, w, pe); check(w, 32'h8765_4321, "R7 restart clears");
      wr(2'd1, 8'h10); wr(2'd1, 8'h20);
      wr(2'd0, 8'h11);
      wr(2'd1, 8'h30); wr(2'd1, 8'h40);
      fetch(9'd2, w, pe); check(w, 32'h4030_2010, "R7 load held keeps lane");
      chk_addr("R7 addr");

      // R9: parity fault detection and its disable
      wr(2'd0, 8'h03);
      inject = 1'b1; load_word(32'h0000_00FF); inject = 1'b0;
      load_word(32'h0000_0001);
      fetch(9'd0, w, pe); check(pe, 1'b1, "R9 detect");
      fetch(9'd1, w, pe); check(pe, 1'b0, "R9 good word");
      wr(2'd0, 8'h81);
      fetch(9'd0, w, pe); check(pe, 1'b0, "R9 suppressed");

      // R8/R10: walk to 511 and wrap
      wr(2'd0, 8'h03);
      for (int i = 0; i < 511; i++) load_word($urandom);
      chk_addr("R10 addr 511");
      rd(2'd3, v); check(v, 8'h01, "R10 high reg");
      load_word(32'hFEED_0511);
      chk_addr("R8 wrap");
      fetch(9'd511, w, pe); check(w, 32'hFEED_0511, "R8 top word");

      // random mix
      for (int i = 0; i < 3000; i++) begin
         int r = $urandom_range(0, 99);
         if (r < 85) wr(2'd1, 8'($urandom));
         else if (r < 90) wr(2'd0, {$urandom_range(0,1) == 1 ? 8'h80 : 8'h00} | 8'h01);
         else if (r < 94) wr(2'd0, 8'h00);
         else if (r < 97) wr(2'd0, 8'h83);
         else chk_addr("R4 random addr");
      end
      chk_addr("R4 random final");
      for (int a = 0; a < 512; a += 7) begin
         if (m_val[a]) begin
            fetch(9'(a), w, pe);
            check(w, m_mem[a], "R3 random word");
            check(pe, 1'b0, "R9 random parity");
         end
      end

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule